// File: doc/BRIEF.md
# Time-of-Day Aligned Pin Waveform Generator

This block keeps a running time of day, made of a nanosecond count and a seconds count, and drives one timing pin from it. A 32-bit register port sets a high time and a low time in nanoseconds, plus an action selector, a sync enable and a polarity bit. With sync on, the pin fires once per second. The pulse opens the low time after the seconds count steps and stays open for the high time, which makes a pulse-per-second output. With sync off, the same two times shape a free-running square wave, high for the high time and low for the low time.

Pin edges come from comparing nanosecond quantities: the time-of-day nanoseconds in sync mode, and a phase accumulator that steps by the clock increment in periodic mode. Edges therefore stay locked to the time base instead of to a separate cycle count. Register writes go to a staging copy. The copy is moved into the running configuration only at a safe boundary, so a reprogram never produces a runt pulse.

Top module: `tod_pulse_gen`

## Requirements
- R1: Every clock the nanosecond count grows by `NS_INC`. When it would reach `NS_WRAP` it wraps to its remainder (0 when `NS_WRAP` is a multiple of `NS_INC`) and the seconds count grows by one. Both counts reset to 0.
- R2: Registers are at byte offset 0x00 (config), 0x14 (high time) and 0x18 (low time). Config bits are: bit 0 domain, bit 2 sync, bits 4:3 action (1 = clock, any other value = idle), bit 5 polarity. All other config bits read 0. A read returns the staged value on `regRvalid` one cycle later. Writes to other offsets change nothing, and reads of other offsets return 0. `regReady` is always 1.
- R3: With action clock and sync on, the pin is active in the cycle after the nanosecond count `ns` satisfies low ≤ ns < min(low+high, `NS_WRAP`−`NS_INC`). This gives exactly one pulse per second.
- R4: After reset the high time reads 1000 and the low time reads 0. With sync enabled these give a pulse of 1000 ns that starts at the seconds boundary.
- R5: With action clock and sync off, a phase accumulator steps by `NS_INC` modulo (high+low). The pin is active in the cycle after phase < high, and the phase restarts at 0 when a configuration is applied.
- R6: Polarity 1 inverts the pin. The inactive level equals the polarity bit, and the reset level is 0.
- R7: When the running action is idle, or in any cycle with a register write, the pin goes to its inactive level on the next clock.
- R8: Staged values take effect at a boundary, and never in a write cycle. In sync mode the boundary is the seconds wrap. In periodic mode it is the phase wrap. In idle it is the next cycle.
- R9: High or low times of `NS_WRAP` or more are clamped to `NS_WRAP`. A low time at or beyond the wrap gives no pulse at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regValid | input | 1 | Register access request |
| regReady | output | 1 | Access accepted (always 1) |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data |
| regRvalid | output | 1 | Read data valid, one cycle after the read |
| todNs | output | NS_W | Time-of-day nanoseconds |
| todSec | output | SEC_W | Time-of-day seconds |
| pinOut | output | 1 | Timing pin |

## Verification
The hardest case to reach is a reprogram that lands partway through a second or partway through a periodic cycle. The bench must show that the old shape carries on until the boundary and that the new shape starts cleanly at it. The bench shrinks the second to 2000 ns (400 clocks) so that many boundaries pass in a short run. It writes new times at arbitrary points in the period. A cycle-by-cycle arithmetic model of the counters, the staging and the pin runs next to the design. Window counts of active cycles and rising edges add pulse-width and pulse-count checks for the default, clamped, inverted and non-multiple-of-increment settings.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] ACT_IDLE  = 2'd0;
  localparam logic [1:0] ACT_CLOCK = 2'd1;

  localparam logic [7:0] ADDR_CFG  = 8'h00;
  localparam logic [7:0] ADDR_HIGH = 8'h14;
  localparam logic [7:0] ADDR_LOW  = 8'h18;

  localparam int BIT_DOM  = 0;
  localparam int BIT_SYNC = 2;
  localparam int BIT_ACT  = 3;
  localparam int BIT_POL  = 5;

  typedef struct packed {
    logic              pol;
    logic [1:0]        action;
    logic              sync;
    logic              domain;
    logic [DATA_W-1:0] high;
    logic [DATA_W-1:0] low;
  } pin_cfg_t;

  typedef struct packed {
    logic apply;
    logic forceIdle;
  } ctl_strobe_t;

  localparam pin_cfg_t CFG_RESET = '{
    pol: 1'b0, action: ACT_IDLE, sync: 1'b0, domain: 1'b0,
    high: 32'd1000, low: 32'd0
  };
endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRvalid,
  input  logic              secEdge,
  input  logic              cycEdge,
  output pin_cfg_t          actCfg,
  output ctl_strobe_t       strobe
);
  pin_cfg_t stageCfg;
  logic     pending;
  logic     writeHit;
  logic     readHit;
  logic     mapped;
  logic     boundary;
  logic     actIsClock;
  logic [DATA_W-1:0] readMux;

  assign writeHit   = regValid && regWrite;
  assign readHit    = regValid && !regWrite;
  assign mapped     = (regAddr == ADDR_CFG) || (regAddr == ADDR_HIGH) || (regAddr == ADDR_LOW);
  assign actIsClock = (actCfg.action == ACT_CLOCK);

  // R8: boundary selection per running mode
  assign boundary = !actIsClock || (actCfg.sync ? secEdge : cycEdge);

  assign strobe.apply     = pending && boundary && !writeHit;
  assign strobe.forceIdle = writeHit || !actIsClock;

  always_comb begin
    readMux = '0;
    case (regAddr)
      ADDR_CFG: begin
        readMux[BIT_DOM]           = stageCfg.domain;
        readMux[BIT_SYNC]          = stageCfg.sync;
        readMux[BIT_ACT+1:BIT_ACT] = stageCfg.action;
        readMux[BIT_POL]           = stageCfg.pol;
      end
      ADDR_HIGH: readMux = stageCfg.high;
      ADDR_LOW:  readMux = stageCfg.low;
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageCfg  <= CFG_RESET;
      actCfg    <= CFG_RESET;
      pending   <= 1'b0;
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      regRvalid <= readHit;
      if (readHit) regRdata <= readMux;
      if (strobe.apply) actCfg <= stageCfg;
      if (writeHit) begin
        case (regAddr)
          ADDR_CFG: begin
            stageCfg.domain <= regWdata[BIT_DOM];
            stageCfg.sync   <= regWdata[BIT_SYNC];
            stageCfg.action <= regWdata[BIT_ACT+1:BIT_ACT];
            stageCfg.pol    <= regWdata[BIT_POL];
          end
          ADDR_HIGH: stageCfg.high <= regWdata;
          ADDR_LOW:  stageCfg.low  <= regWdata;
          default: ;
        endcase
      end
      if (writeHit && mapped) pending <= 1'b1;
      else if (strobe.apply)  pending <= 1'b0;
    end
  end
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int NS_INC  = 5,
  parameter int NS_WRAP = 1000000000,
  parameter int SEC_W   = 48,
  parameter int NS_W    = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  pin_cfg_t         actCfg,
  input  ctl_strobe_t      strobe,
  output logic [NS_W-1:0]  todNs,
  output logic [SEC_W-1:0] todSec,
  output logic             secEdge,
  output logic             cycEdge,
  output logic             pinOut
);
  localparam int W2 = NS_W + 2;
  localparam logic [W2-1:0] WRAP_V = W2'(NS_WRAP);
  localparam logic [W2-1:0] INC_V  = W2'(NS_INC);
  localparam logic [W2-1:0] LAST_V = WRAP_V - INC_V;

  logic [W2-1:0] phase;
  logic [W2-1:0] nsExt, nsNext;
  logic [W2-1:0] hiC, loC, period, pulseEnd, sumHL;
  logic [W2-1:0] phaseInc, phaseNext;
  logic          syncRaw, perRaw, rawLvl;

  function automatic logic [W2-1:0] clampNs(input logic [DATA_W-1:0] v);
    if (v >= DATA_W'(NS_WRAP)) return WRAP_V;
    return W2'(v);
  endfunction

  assign nsExt   = W2'(todNs);
  assign secEdge = (nsExt >= LAST_V);
  assign nsNext  = secEdge ? (nsExt + INC_V - WRAP_V) : (nsExt + INC_V);

  // R9: clamp programmed times
  assign hiC      = clampNs(actCfg.high);
  assign loC      = clampNs(actCfg.low);
  assign sumHL    = hiC + loC;
  assign period   = sumHL;
  assign pulseEnd = (sumHL > LAST_V) ? LAST_V : sumHL;

  // R3: compare against time-of-day nanoseconds
  assign syncRaw = (nsExt >= loC) && (nsExt < pulseEnd);

  // R5: phase accumulator in nanoseconds
  assign phaseInc  = phase + INC_V;
  assign cycEdge   = (period == '0) || (phaseInc >= period);
  assign phaseNext = (period == '0) ? '0 :
                     (phaseInc >= period) ? (phaseInc - period) : phaseInc;
  assign perRaw    = (period != '0) && (phase < hiC);

  assign rawLvl = actCfg.sync ? syncRaw : perRaw;

  always_ff @(posedge clk) begin
    if (rst) begin
      todNs  <= '0;
      todSec <= '0;
      phase  <= '0;
      pinOut <= 1'b0;
    end else begin
      todNs <= nsNext[NS_W-1:0];
      if (secEdge) todSec <= todSec + 1'b1;
      phase  <= strobe.apply ? '0 : phaseNext;
      pinOut <= strobe.forceIdle ? actCfg.pol : (rawLvl ^ actCfg.pol);
    end
  end
endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
  import tpg_pkg::*;
#(
  parameter int NS_INC  = 5,
  parameter int NS_WRAP = 1000000000,
  parameter int SEC_W   = 48,
  localparam int NS_W   = $clog2(NS_WRAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regValid,
  output logic              regReady,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRvalid,
  output logic [NS_W-1:0]   todNs,
  output logic [SEC_W-1:0]  todSec,
  output logic              pinOut
);
  pin_cfg_t    actCfg;
  ctl_strobe_t strobe;
  logic        secEdge, cycEdge;
  logic        actPol, actClock;

  assign regReady = 1'b1;
  assign actPol   = actCfg.pol;
  assign actClock = (actCfg.action == ACT_CLOCK);

  tpg_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regRvalid(regRvalid),
    .secEdge(secEdge), .cycEdge(cycEdge),
    .actCfg(actCfg), .strobe(strobe)
  );

  tpg_datapath #(
    .NS_INC(NS_INC), .NS_WRAP(NS_WRAP), .SEC_W(SEC_W), .NS_W(NS_W)
  ) dp_i (
    .clk(clk), .rst(rst),
    .actCfg(actCfg), .strobe(strobe),
    .todNs(todNs), .todSec(todSec),
    .secEdge(secEdge), .cycEdge(cycEdge),
    .pinOut(pinOut)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int NS_WRAP = 1000000000,
  parameter int NS_W    = 30,
  parameter int SEC_W   = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             regValid,
  input logic             regWrite,
  input logic             regRvalid,
  input logic             regReady,
  input logic [NS_W-1:0]  todNs,
  input logic [SEC_W-1:0] todSec,
  input logic             pinOut,
  input logic             actPol,
  input logic             actClock
);
  assert_ns_range_R1: assert property (@(posedge clk) disable iff (rst)
    todNs < NS_W'(NS_WRAP));

  assert_sec_step_R1: assert property (@(posedge clk) disable iff (rst)
    (todNs < $past(todNs)) |-> (todSec == $past(todSec) + 1'b1));

  assert_sec_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (todNs > $past(todNs)) |-> $stable(todSec));

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (regValid && !regWrite) |=> regRvalid);

  assert_no_spurious_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    !(regValid && !regWrite) |=> !regRvalid);

  assert_ready_R2: assert property (@(posedge clk) disable iff (rst) regReady);

  assert_write_inactive_R7: assert property (@(posedge clk) disable iff (rst)
    (regValid && regWrite) |=> (pinOut == $past(actPol)));

  assert_idle_inactive_R7: assert property (@(posedge clk) disable iff (rst)
    !actClock |=> (pinOut == $past(actPol)));
endmodule

bind tod_pulse_gen tpg_checker #(.NS_WRAP(NS_WRAP), .NS_W(NS_W), .SEC_W(SEC_W)) chk_i (
  .clk(clk), .rst(rst), .regValid(regValid), .regWrite(regWrite),
  .regRvalid(regRvalid), .regReady(regReady), .todNs(todNs), .todSec(todSec),
  .pinOut(pinOut), .actPol(actPol), .actClock(actClock)
);

// File: tb/tod_pulse_gen_tb_top.sv
module tod_pulse_gen_tb_top;
  localparam int INC  = 5;
  localparam int WRAP = 2000;
  localparam int NW   = $clog2(WRAP + 1);
  localparam int SPS  = WRAP / INC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regReady, regRvalid, pinOut;
  logic [31:0] regRdata;
  logic [NW-1:0] todNs;
  logic [47:0] todSec;

  int tests = 0, fails = 0;
  string phaseReq = "R1";

  always #2.5 clk = ~clk;

  tod_pulse_gen #(.NS_INC(INC), .NS_WRAP(WRAP), .SEC_W(48)) dut_i (
    .clk(clk), .rst(rst), .regValid(regValid), .regReady(regReady),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .regRvalid(regRvalid), .todNs(todNs),
    .todSec(todSec), .pinOut(pinOut)
  );

  // model state
  longint mNs = 0, mSec = 0, mPh = 0;
  bit mPin = 0, mRv = 0;
  longint mRd = 0;
  bit sPol = 0, sSync = 0, sDom = 0; int sAct = 0; longint sHigh = 1000, sLow = 0;
  bit aPol = 0, aSync = 0, aDom = 0; int aAct = 0; longint aHigh = 1000, aLow = 0;
  bit pend = 0;

  function automatic longint clampM(longint v);
    return (v >= WRAP) ? WRAP : v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d", req, phaseReq, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d);
    longint lc, hc, per, last, phInc, phN, pend2, rdN;
    bit wrEv, rdEv, mapped, wrapNow, cyc, isClk, bnd, apply, raw;
    string tag;
    regValid = v; regWrite = w; regAddr = a; regWdata = d;
    wrEv = v && w; rdEv = v && !w;
    mapped = (a == 8'h00) || (a == 8'h14) || (a == 8'h18);
    lc = clampM(aLow); hc = clampM(aHigh); per = lc + hc; last = WRAP - INC;
    wrapNow = mNs >= last;
    phInc = mPh + INC;
    cyc = (per == 0) || (phInc >= per);
    phN = (per == 0) ? 0 : ((phInc >= per) ? phInc - per : phInc);
    isClk = (aAct == 1);
    bnd = !isClk || (aSync ? wrapNow : cyc);
    apply = pend && bnd && !wrEv;
    pend2 = ((hc + lc) < last) ? hc + lc : last;
    raw = aSync ? ((mNs >= lc) && (mNs < pend2)) : ((per != 0) && (mPh < hc));
    tag = (wrEv || !isClk) ? "R7" : (aSync ? (aPol ? "R3/R6" : "R3") : (aPol ? "R5/R6" : "R5"));
    mPin = (wrEv || !isClk) ? aPol : (raw ^ aPol);
    case (a)
      8'h00: rdN = (longint'(sPol) << 5) | (longint'(sAct) << 3) | (longint'(sSync) << 2) | longint'(sDom);
      8'h14: rdN = sHigh;
      8'h18: rdN = sLow;
      default: rdN = 0;
    endcase
    mNs = wrapNow ? mNs + INC - WRAP : mNs + INC;
    if (wrapNow) mSec++;
    mPh = apply ? 0 : phN;
    if (apply) begin
      aPol = sPol; aSync = sSync; aDom = sDom; aAct = sAct; aHigh = sHigh; aLow = sLow;
    end
    if (wrEv) begin
      case (a)
        8'h00: begin sDom = d[0]; sSync = d[2]; sAct = int'(d[4:3]); sPol = d[5]; end
        8'h14: sHigh = longint'(d);
        8'h18: sLow = longint'(d);
        default: ;
      endcase
    end
    if (wrEv && mapped) pend = 1; else if (apply) pend = 0;
    mRv = rdEv;
    if (rdEv) mRd = rdN;
    @(posedge clk); @(negedge clk);
    regValid = 0; regWrite = 0;
    chk(longint'(todNs) == mNs && longint'(todSec) == mSec, "R1 tod", longint'(todNs), mNs);
    chk(pinOut == mPin, tag, longint'(pinOut), longint'(mPin));
    chk(regRvalid == mRv, "R2 rvalid", longint'(regRvalid), longint'(mRv));
    if (mRv) chk(longint'(regRdata) == mRd, "R2 rdata", longint'(regRdata), mRd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 32'h0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(1, 1, a, d);
  endtask

  task automatic rd(logic [7:0] a, longint exp, string req);
    step(1, 0, a, 32'h0);
    chk(longint'(regRdata) == exp, req, longint'(regRdata), exp);
  endtask

  task automatic countWin(int n, output int highs, output int rises);
    bit prev;
    highs = 0; rises = 0; prev = pinOut;
    for (int i = 0; i < n; i++) begin
      step(0, 0, 8'h00, 32'h0);
      if (pinOut) highs++;
      if (pinOut && !prev) rises++;
      prev = pinOut;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (phase %s) actual=timeout expected=done", phaseReq);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int h, r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state (R1, R6)
    chk(todNs == 0 && todSec == 0, "R1 reset tod", longint'(todNs), 0);
    chk(pinOut == 1'b0, "R6 reset pin", longint'(pinOut), 0);
    chk(regRvalid == 1'b0, "R2 reset rvalid", longint'(regRvalid), 0);
    chk(regReady == 1'b1, "R2 ready", longint'(regReady), 1);

    phaseReq = "R4";
    rd(8'h00, 0, "R2 cfg reset");
    rd(8'h14, 1000, "R4 high reset");
    rd(8'h18, 0, "R4 low reset");

    // sync PPS with defaults
    wr(8'h00, 32'h0000_000D);   // domain, sync, action clock
    rd(8'h00, 32'h0D, "R2 cfg readback");
    idle(2 * SPS);
    countWin(SPS, h, r);
    chk(h == 1000 / INC, "R4 pulse width", h, 1000 / INC);
    chk(r == 1, "R3 pulses per second", r, 1);

    // mid-second reprogram (R8)
    phaseReq = "R8";
    idle(137);
    wr(8'h18, 32'd500);
    idle(41);
    wr(8'h14, 32'd300);
    rd(8'h14, 300, "R2 high readback");
    idle(2 * SPS);
    countWin(SPS, h, r);
    chk(h == 300 / INC, "R3 width after reprogram", h, 300 / INC);
    chk(r == 1, "R3 one pulse after reprogram", r, 1);

    // polarity (R6)
    phaseReq = "R6";
    wr(8'h00, 32'h0000_002C);
    idle(2 * SPS);
    countWin(SPS, h, r);
    chk(h == SPS - 300 / INC, "R6 inverted active count", h, SPS - 300 / INC);

    // clamps (R9)
    phaseReq = "R9";
    wr(8'h00, 32'h0000_000C);
    wr(8'h18, 32'd5000);
    idle(2 * SPS);
    countWin(SPS, h, r);
    chk(h == 0, "R9 low beyond wrap no pulse", h, 0);
    wr(8'h18, 32'd100);
    wr(8'h14, 32'hFFFF_FFF0);
    idle(2 * SPS);
    countWin(SPS, h, r);
    chk(h == (WRAP - INC - 100) / INC, "R9 high clamped", h, (WRAP - INC - 100) / INC);
    chk(r == 1, "R9 single pulse", r, 1);

    // periodic (R5)
    phaseReq = "R5";
    wr(8'h14, 32'd35);
    wr(8'h18, 32'd20);
    wr(8'h00, 32'h0000_0008);
    idle(2 * SPS);
    countWin(550, h, r);
    chk(h == 350, "R5 duty 35/20", h, 350);
    chk(r == 50, "R5 cycles 35/20", r, 50);
    wr(8'h14, 32'd17);
    idle(23);
    wr(8'h18, 32'd13);
    idle(100);
    countWin(600, h, r);
    chk(h == 400, "R5 duty 17/13", h, 400);
    wr(8'h14, 32'd0);
    idle(60);
    countWin(60, h, r);
    chk(h == 0, "R5 zero high", h, 0);
    wr(8'h14, 32'd40);
    wr(8'h18, 32'd0);
    idle(60);
    countWin(60, h, r);
    chk(h == 60, "R5 zero low", h, 60);

    // idle action (R7)
    phaseReq = "R7";
    wr(8'h00, 32'h0000_0020);
    idle(30);
    countWin(100, h, r);
    chk(h == 100, "R7 idle inverted inactive", h, 100);
    wr(8'h00, 32'h0000_0018);   // action 3 = idle
    idle(30);
    countWin(100, h, r);
    chk(h == 0, "R7 idle code 3", h, 0);

    // unmapped offsets (R2)
    phaseReq = "R2";
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, 0, "R2 unmapped read");
    rd(8'h14, 40, "R2 high unchanged");
    rd(8'h18, 0, "R2 low unchanged");
    rd(8'h00, 32'h18, "R2 cfg unchanged");
    idle(SPS);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule